// File: doc/BRIEF.md
# Two-Rate Three-Color Packet Policer

This block meters an ingress packet stream against two token buckets, a committed bucket and a peak bucket. Each bucket is set by a refill amount and a capacity. Both are written in a compact mantissa/exponent form that stands for (1 + M/256) · 2^E tokens. A free-running 2 µs time-unit strobe, divided down by a power of two, tops up both buckets. Bucket contents are kept with 8 fractional bits, so costs down to 1/256 of a token are exact.

For every packet strobe, the block works out a token cost. In byte mode the cost comes from the packet length minus a header offset. In packet mode the length is ignored. In both modes a signed mantissa/exponent adjustment is added. The block then tries the committed bucket and then the peak bucket, and marks the packet green, yellow or red. It debits only the bucket that covered the packet. A programmable action per color turns the color into a pass or drop result one clock later. The color of an incoming packet can be ignored (color-blind) or honoured (color-aware).

Top module: `trtcm_policer`

## Requirements
- R1: After reset the result strobe is low with color and drop at 0, and both buckets are full: the first packet whose cost fits the committed capacity is green.
- R2: The committed bucket gains (256+M)·2^E/256 tokens, and the peak bucket its own amount, on every 2^rdiv-th time-unit strobe (rdiv 0 means every strobe).
- R3: A bucket never holds more than its capacity (256+M)·2^E/256 tokens, however many refills arrive while it is full.
- R4: An exponent field of 24 or above is treated as 24. Exponent 24 with mantissa 0 means zero rate and zero capacity, so that bucket never covers a packet.
- R5: In byte mode (mode bit 0) the length term is packet length minus the offset field, clamped at 0, in whole tokens.
- R6: The cost is length term + (ADJ_M − 256)·2^ADJ_E/256 tokens. In packet mode (mode bit 1) the length term is 0, so ADJ_M = 384 and ADJ_E = 1 charge exactly one token per packet.
- R7: A cost that works out at or below zero is raised to 1/256 token, and that amount is debited.
- R8: A packet is green if the committed bucket covers its cost, which is then debited from the committed bucket. Otherwise it is yellow if the peak bucket covers the cost, which is then debited from the peak bucket. Otherwise it is red, and neither bucket changes.
- R9: Each color has a 2-bit action. Code 1 drops the packet and every other code passes it. Color codes are 0 green, 1 yellow, 2 red.
- R10: Color-mode value 3 is color-blind: the incoming color is ignored. Any other mode is color-aware: an incoming yellow packet cannot become green, and an incoming red packet (code 2 or 3) stays red.
- R11: The result appears with the result strobe in the cycle after the packet strobe. A refill and a debit in the same cycle are applied refill first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 2 µs time-unit strobe |
| cfg_cir_exp | input | 5 | Committed refill exponent |
| cfg_cir_man | input | 8 | Committed refill mantissa |
| cfg_cbs_exp | input | 5 | Committed capacity exponent |
| cfg_cbs_man | input | 8 | Committed capacity mantissa |
| cfg_pir_exp | input | 5 | Peak refill exponent |
| cfg_pir_man | input | 8 | Peak refill mantissa |
| cfg_pbs_exp | input | 5 | Peak capacity exponent |
| cfg_pbs_man | input | 8 | Peak capacity mantissa |
| cfg_rdiv | input | 4 | Refill divider, log2 of strobes per refill |
| cfg_adj_exp | input | 5 | Cost adjustment exponent |
| cfg_adj_man | input | 9 | Cost adjustment mantissa |
| cfg_pkt_mode | input | 1 | 1 = packet mode, 0 = byte mode |
| cfg_len_off | input | 8 | Bytes subtracted from length in byte mode |
| cfg_color_mode | input | 2 | 3 = color-blind, other = color-aware |
| cfg_act_green | input | 2 | Action for green |
| cfg_act_yellow | input | 2 | Action for yellow |
| cfg_act_red | input | 2 | Action for red |
| pkt_valid | input | 1 | Packet strobe |
| pkt_len | input | 16 | Packet length in bytes |
| pkt_color | input | 2 | Incoming packet color |
| res_valid | output | 1 | Result strobe |
| res_color | output | 2 | Assigned color |
| res_drop | output | 1 | 1 = drop, 0 = pass |

## Verification
The assertions watch, on every cycle, the one-cycle result timing and the decision order. A green packet must have been covered by the committed level and must have lowered that level by exactly its cost. A red packet must leave both levels untouched. They also check that a red input in color-aware mode stays red, that a disabled committed bucket never yields green, that the drop action for red is obeyed, and that the cost is never zero. Only the bench scenarios can show the token arithmetic end to end: the refill amounts, the divider spacing, the capacity cap, the fractional floor cost, the length offset, the one-token packet mode, and the buckets being full after reset.

// File: rtl/trtcm_pkg.sv
package trtcm_pkg;
  localparam int          FRAC_W     = 8;
  localparam logic [1:0]  COL_GREEN  = 2'd0;
  localparam logic [1:0]  COL_YELLOW = 2'd1;
  localparam logic [1:0]  COL_RED    = 2'd2;
  localparam logic [1:0]  ACT_DROP   = 2'd1;
  localparam logic [1:0]  MODE_BLIND = 2'd3;
endpackage

// File: rtl/trtcm_refill_timer.sv
// Divides the time-unit strobe by 2^rdiv (R2).
module trtcm_refill_timer #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] rdiv,
  output logic             refill
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             cnt_en;

  always_comb begin
    limit  = (CNT_W'(1) << rdiv) - CNT_W'(1);
    refill = tick && (cnt_q >= limit);
    cnt_en = tick;
    cnt_d  = refill ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/trtcm_token_bucket.sv
// One bucket: decode of rate and capacity, refill-then-debit (R2, R3, R4, R11).
module trtcm_token_bucket #(
  parameter int EXP_W   = 5,
  parameter int MAN_W   = 8,
  parameter int EXP_MAX = 24,
  parameter int LVL_W   = MAN_W + EXP_MAX + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refill,
  input  logic [EXP_W-1:0] rate_exp,
  input  logic [MAN_W-1:0] rate_man,
  input  logic [EXP_W-1:0] size_exp,
  input  logic [MAN_W-1:0] size_man,
  input  logic             debit,
  input  logic [LVL_W-1:0] debit_amt,
  output logic [LVL_W-1:0] avail,
  output logic [LVL_W-1:0] level
);
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(EXP_MAX);

  function automatic logic [LVL_W-1:0] me_value(input logic [EXP_W-1:0] e,
                                                input logic [MAN_W-1:0] m);
    logic [EXP_W-1:0] ec;
    logic [LVL_W-1:0] v;
    ec = (e > EXP_CAP) ? EXP_CAP : e;
    v  = LVL_W'({1'b1, m}) << ec;
    if (ec == EXP_CAP && m == '0) v = '0;
    return v;
  endfunction

  logic [LVL_W-1:0] rate, size, lvl_q, lvl_d;
  logic [LVL_W:0]   sum;

  always_comb begin
    rate  = me_value(rate_exp, rate_man);
    size  = me_value(size_exp, size_man);
    sum   = {1'b0, lvl_q} + (refill ? {1'b0, rate} : '0);
    avail = (sum > {1'b0, size}) ? size : sum[LVL_W-1:0];
    lvl_d = debit ? avail - debit_amt : avail;
  end

  // Reset to all ones: the cap turns that into "full" for any capacity (R1).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl_d;
  end

  assign level = lvl_q;
endmodule

// File: rtl/trtcm_cost_calc.sv
// Per-packet token cost in 1/256 units (R5, R6, R7).
module trtcm_cost_calc #(
  parameter int LEN_W   = 16,
  parameter int OFF_W   = 8,
  parameter int EXP_W   = 5,
  parameter int AMAN_W  = 9,
  parameter int EXP_MAX = 24,
  parameter int LVL_W   = 34
) (
  input  logic              pkt_mode,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [OFF_W-1:0]  len_off,
  input  logic [EXP_W-1:0]  adj_exp,
  input  logic [AMAN_W-1:0] adj_man,
  output logic [LVL_W-1:0]  cost
);
  import trtcm_pkg::*;
  localparam int               SW      = LVL_W + 2;
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(EXP_MAX);

  logic [LEN_W-1:0]        len_term;
  logic [EXP_W-1:0]        ec;
  logic signed [AMAN_W:0]  m_s;
  logic [SW-1:0]           base_u;
  logic signed [SW-1:0]    adj, tot;

  always_comb begin
    if (pkt_mode)                         len_term = '0;
    else if (pkt_len > LEN_W'(len_off))   len_term = pkt_len - LEN_W'(len_off);
    else                                  len_term = '0;
    ec     = (adj_exp > EXP_CAP) ? EXP_CAP : adj_exp;
    m_s    = $signed({1'b0, adj_man}) - $signed((AMAN_W+1)'(256));
    base_u = SW'(len_term) << FRAC_W;
    adj    = $signed({{(SW-AMAN_W-1){m_s[AMAN_W]}}, m_s}) <<< ec;
    tot    = $signed(base_u) + adj;
    cost   = (tot <= 0) ? LVL_W'(1) : tot[LVL_W-1:0];
  end
endmodule

// File: rtl/trtcm_policer.sv
module trtcm_policer #(
  parameter int LEN_W   = 16,
  parameter int OFF_W   = 8,
  parameter int EXP_W   = 5,
  parameter int MAN_W   = 8,
  parameter int AMAN_W  = 9,
  parameter int DIV_W   = 4,
  parameter int EXP_MAX = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [EXP_W-1:0]  cfg_cir_exp,
  input  logic [MAN_W-1:0]  cfg_cir_man,
  input  logic [EXP_W-1:0]  cfg_cbs_exp,
  input  logic [MAN_W-1:0]  cfg_cbs_man,
  input  logic [EXP_W-1:0]  cfg_pir_exp,
  input  logic [MAN_W-1:0]  cfg_pir_man,
  input  logic [EXP_W-1:0]  cfg_pbs_exp,
  input  logic [MAN_W-1:0]  cfg_pbs_man,
  input  logic [DIV_W-1:0]  cfg_rdiv,
  input  logic [EXP_W-1:0]  cfg_adj_exp,
  input  logic [AMAN_W-1:0] cfg_adj_man,
  input  logic              cfg_pkt_mode,
  input  logic [OFF_W-1:0]  cfg_len_off,
  input  logic [1:0]        cfg_color_mode,
  input  logic [1:0]        cfg_act_green,
  input  logic [1:0]        cfg_act_yellow,
  input  logic [1:0]        cfg_act_red,
  input  logic              pkt_valid,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [1:0]        pkt_color,
  output logic              res_valid,
  output logic [1:0]        res_color,
  output logic              res_drop
);
  import trtcm_pkg::*;
  localparam int LVL_W = MAN_W + EXP_MAX + 2;
  localparam int NBKT  = 2;   // 0 = committed, 1 = peak

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic refill;
  trtcm_refill_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .rdiv(cfg_rdiv), .refill(refill)
  );

  logic [LVL_W-1:0] cost;
  trtcm_cost_calc #(
    .LEN_W(LEN_W), .OFF_W(OFF_W), .EXP_W(EXP_W), .AMAN_W(AMAN_W),
    .EXP_MAX(EXP_MAX), .LVL_W(LVL_W)
  ) u_cost (
    .pkt_mode(cfg_pkt_mode), .pkt_len(pkt_len), .len_off(cfg_len_off),
    .adj_exp(cfg_adj_exp), .adj_man(cfg_adj_man), .cost(cost)
  );

  logic [EXP_W-1:0] r_exp [NBKT];
  logic [MAN_W-1:0] r_man [NBKT];
  logic [EXP_W-1:0] s_exp [NBKT];
  logic [MAN_W-1:0] s_man [NBKT];
  logic             deb   [NBKT];
  logic [LVL_W-1:0] avail [NBKT];
  logic [LVL_W-1:0] lvl   [NBKT];

  assign r_exp[0] = cfg_cir_exp;  assign r_man[0] = cfg_cir_man;
  assign s_exp[0] = cfg_cbs_exp;  assign s_man[0] = cfg_cbs_man;
  assign r_exp[1] = cfg_pir_exp;  assign r_man[1] = cfg_pir_man;
  assign s_exp[1] = cfg_pbs_exp;  assign s_man[1] = cfg_pbs_man;

  for (genvar b = 0; b < NBKT; b++) begin : g_bkt
    trtcm_token_bucket #(
      .EXP_W(EXP_W), .MAN_W(MAN_W), .EXP_MAX(EXP_MAX), .LVL_W(LVL_W)
    ) u_bkt (
      .clk(clk), .rst_n(rst_sync_n), .refill(refill),
      .rate_exp(r_exp[b]), .rate_man(r_man[b]),
      .size_exp(s_exp[b]), .size_man(s_man[b]),
      .debit(deb[b]), .debit_amt(cost),
      .avail(avail[b]), .level(lvl[b])
    );
  end

  // Color decision (R8, R10) and action (R9).
  logic [1:0] in_col, col_d, act;
  logic       drop_d, out_en;

  always_comb begin
    if (cfg_color_mode == MODE_BLIND) in_col = COL_GREEN;
    else if (pkt_color[1])            in_col = COL_RED;
    else                              in_col = pkt_color;
    deb[0] = 1'b0;
    deb[1] = 1'b0;
    if (in_col == COL_GREEN && avail[0] >= cost) begin
      col_d  = COL_GREEN;
      deb[0] = pkt_valid;
    end else if (in_col != COL_RED && avail[1] >= cost) begin
      col_d  = COL_YELLOW;
      deb[1] = pkt_valid;
    end else begin
      col_d  = COL_RED;
    end
    case (col_d)
      COL_GREEN:  act = cfg_act_green;
      COL_YELLOW: act = cfg_act_yellow;
      default:    act = cfg_act_red;
    endcase
    drop_d = (act == ACT_DROP);
    out_en = pkt_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) res_valid <= 1'b0;
    else             res_valid <= pkt_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_color <= '0;
      res_drop  <= 1'b0;
    end else if (out_en) begin
      res_color <= col_d;
      res_drop  <= drop_d;
    end
  end
endmodule

// File: rtl/trtcm_policer_chk.sv
module trtcm_policer_chk #(
  parameter int EXP_W   = 5,
  parameter int MAN_W   = 8,
  parameter int EXP_MAX = 24,
  parameter int LVL_W   = 34
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic [1:0]       pkt_color,
  input logic [1:0]       cfg_color_mode,
  input logic [EXP_W-1:0] cfg_cbs_exp,
  input logic [MAN_W-1:0] cfg_cbs_man,
  input logic [1:0]       cfg_act_red,
  input logic             res_valid,
  input logic [1:0]       res_color,
  input logic             res_drop,
  input logic [LVL_W-1:0] cost,
  input logic [LVL_W-1:0] c_avail,
  input logic [LVL_W-1:0] p_avail,
  input logic [LVL_W-1:0] c_level,
  input logic [LVL_W-1:0] p_level
);
  a_r11_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> res_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !res_valid);
  a_r8_green_debit: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_color == 2'd0) |->
      ($past(c_avail) >= $past(cost) && c_level == $past(c_avail) - $past(cost)));
  a_r8_red_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_color == 2'd2) |->
      (c_level == $past(c_avail) && p_level == $past(p_avail)));
  a_r10_red_stays_red: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && cfg_color_mode != 2'd3 && pkt_color[1]) |=> res_color == 2'd2);
  a_r4_disabled_never_green: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && cfg_cbs_man == '0 && cfg_cbs_exp >= EXP_W'(EXP_MAX)) |=> res_color != 2'd0);
  a_r9_red_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_color == 2'd2 && $past(cfg_act_red) == 2'd1) |-> res_drop);
  a_r7_cost_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> cost != '0);
endmodule

bind trtcm_policer trtcm_policer_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .EXP_MAX(EXP_MAX), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pkt_valid(pkt_valid), .pkt_color(pkt_color),
  .cfg_color_mode(cfg_color_mode), .cfg_cbs_exp(cfg_cbs_exp),
  .cfg_cbs_man(cfg_cbs_man), .cfg_act_red(cfg_act_red),
  .res_valid(res_valid), .res_color(res_color), .res_drop(res_drop),
  .cost(cost), .c_avail(avail[0]), .p_avail(avail[1]),
  .c_level(lvl[0]), .p_level(lvl[1])
);

// File: tb/test_trtcm_policer.sv
module test_trtcm_policer;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] G = 2'd0, Y = 2'd1, R = 2'd2;

  logic clk, rst_n, tick;
  logic [4:0] cfg_cir_exp, cfg_cbs_exp, cfg_pir_exp, cfg_pbs_exp, cfg_adj_exp;
  logic [7:0] cfg_cir_man, cfg_cbs_man, cfg_pir_man, cfg_pbs_man, cfg_len_off;
  logic [3:0] cfg_rdiv;
  logic [8:0] cfg_adj_man;
  logic       cfg_pkt_mode;
  logic [1:0] cfg_color_mode, cfg_act_green, cfg_act_yellow, cfg_act_red;
  logic       pkt_valid;
  logic [15:0] pkt_len;
  logic [1:0] pkt_color;
  logic       res_valid, res_drop;
  logic [1:0] res_color;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  trtcm_policer i_trtcm_policer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_cir_exp(cfg_cir_exp), .cfg_cir_man(cfg_cir_man),
    .cfg_cbs_exp(cfg_cbs_exp), .cfg_cbs_man(cfg_cbs_man),
    .cfg_pir_exp(cfg_pir_exp), .cfg_pir_man(cfg_pir_man),
    .cfg_pbs_exp(cfg_pbs_exp), .cfg_pbs_man(cfg_pbs_man),
    .cfg_rdiv(cfg_rdiv), .cfg_adj_exp(cfg_adj_exp), .cfg_adj_man(cfg_adj_man),
    .cfg_pkt_mode(cfg_pkt_mode), .cfg_len_off(cfg_len_off),
    .cfg_color_mode(cfg_color_mode), .cfg_act_green(cfg_act_green),
    .cfg_act_yellow(cfg_act_yellow), .cfg_act_red(cfg_act_red),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_color(pkt_color),
    .res_valid(res_valid), .res_color(res_color), .res_drop(res_drop)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ticks before the packet, length, incoming color, expected color, expected drop
  typedef struct packed {
    logic [7:0]  ticks;
    logic [15:0] len;
    logic [1:0]  col_in;
    logic [1:0]  exp_col;
    logic        exp_drop;
  } vec_t;

  // Committed: refill 64, capacity 1024; peak: refill 128, capacity 2048; byte mode.
  localparam vec_t VECS [14] = '{
    '{8'd0,  16'd1000, 2'd0, 2'd0, 1'b0},  // R1 full at start: C 1024->24
    '{8'd0,  16'd100,  2'd0, 2'd1, 1'b0},  // P 2048->1948
    '{8'd0,  16'd24,   2'd0, 2'd0, 1'b0},  // exact fit, C->0
    '{8'd0,  16'd1948, 2'd0, 2'd1, 1'b0},  // P->0
    '{8'd0,  16'd1,    2'd0, 2'd2, 1'b1},  // both empty
    '{8'd1,  16'd64,   2'd0, 2'd0, 1'b0},  // R2 one refill
    '{8'd0,  16'd128,  2'd0, 2'd1, 1'b0},
    '{8'd3,  16'd200,  2'd0, 2'd1, 1'b0},  // C 192, P 384->184
    '{8'd0,  16'd192,  2'd0, 2'd0, 1'b0},
    '{8'd0,  16'd185,  2'd0, 2'd2, 1'b1},  // red leaves P at 184
    '{8'd0,  16'd184,  2'd0, 2'd1, 1'b0},
    '{8'd20, 16'd1025, 2'd0, 2'd1, 1'b0},  // R3 capped at 1024 / 2048
    '{8'd0,  16'd1024, 2'd0, 2'd0, 1'b0},
    '{8'd0,  16'd1024, 2'd0, 2'd2, 1'b1}   // P 1023
  };

  task automatic set_base();
    tick = 0; pkt_valid = 0; pkt_len = '0; pkt_color = G;
    cfg_cir_exp = 5'd6;  cfg_cir_man = 8'd0;
    cfg_cbs_exp = 5'd10; cfg_cbs_man = 8'd0;
    cfg_pir_exp = 5'd7;  cfg_pir_man = 8'd0;
    cfg_pbs_exp = 5'd11; cfg_pbs_man = 8'd0;
    cfg_rdiv = 4'd0; cfg_adj_exp = 5'd0; cfg_adj_man = 9'd256;
    cfg_pkt_mode = 1'b0; cfg_len_off = 8'd0; cfg_color_mode = 2'd3;
    cfg_act_green = 2'd0; cfg_act_yellow = 2'd0; cfg_act_red = 2'd1;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic check(input string req, input logic [1:0] col, input logic drp);
    n_chk++;
    if (!(res_valid === 1'b1 && res_color === col && res_drop === drp)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b color=%0d drop=%0b, expected valid=1 color=%0d drop=%0b",
               req, res_valid, res_color, res_drop, col, drp);
    end
  endtask

  task automatic send(input string req, input logic [15:0] len, input logic [1:0] cin,
                      input logic with_tick, input logic [1:0] col, input logic drp);
    pkt_valid = 1'b1; pkt_len = len; pkt_color = cin; tick = with_tick;
    @(negedge clk);
    pkt_valid = 1'b0; tick = 1'b0;
    check(req, col, drp);
  endtask

  initial begin
    rst_n = 1'b0;
    set_base();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: outputs idle after reset
    n_chk++;
    if (res_valid !== 1'b0 || res_color !== 2'd0 || res_drop !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: valid=%0b color=%0d drop=%0b, expected 0 0 0",
               res_valid, res_color, res_drop);
    end

    // Table: R8 ordering, R2 refill, R3 cap
    foreach (VECS[k]) begin
      do_ticks(int'(VECS[k].ticks));
      send("R8 R2 R3 table", VECS[k].len, VECS[k].col_in, 1'b0,
           VECS[k].exp_col, VECS[k].exp_drop);
    end

    // R11: refill with packet in same cycle, refill first. C 0 -> 64 -> 0, P 1151
    send("R11", 16'd64, G, 1'b1, G, 1'b0);
    // R11: no result strobe without packet
    @(negedge clk);
    n_chk++;
    if (res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: valid=%0b expected 0", res_valid);
    end

    // R2 divider: rdiv 2 refills on every fourth strobe
    cfg_rdiv = 4'd2;
    do_ticks(3);
    send("R2", 16'd1, G, 1'b0, Y, 1'b0);     // C still 0, P 1150
    do_ticks(1);                              // C 64, P 1278
    send("R2", 16'd64, G, 1'b0, G, 1'b0);    // C 0
    cfg_rdiv = 4'd0;

    // R9 actions
    cfg_act_yellow = 2'd1;
    send("R9", 16'd1, G, 1'b0, Y, 1'b1);     // P 1277
    cfg_act_yellow = 2'd0; cfg_act_red = 2'd2;
    send("R9", 16'd2000, G, 1'b0, R, 1'b0);
    cfg_act_red = 2'd1;

    // R10 color-aware then blind
    do_ticks(1);                              // C 64, P 1405
    cfg_color_mode = 2'd0;
    send("R10", 16'd10, Y, 1'b0, Y, 1'b0);   // P 1395
    send("R10", 16'd1,  R, 1'b0, R, 1'b1);
    send("R10", 16'd1,  2'd3, 1'b0, R, 1'b1);
    send("R10", 16'd10, G, 1'b0, G, 1'b0);   // C 54
    cfg_color_mode = 2'd3;
    send("R10", 16'd10, R, 1'b0, G, 1'b0);   // C 44

    // R5 offset, R7 floor
    cfg_len_off = 8'd20;
    send("R5", 16'd30, G, 1'b0, G, 1'b0);    // cost 10, C 34
    send("R7", 16'd10, G, 1'b0, G, 1'b0);    // cost 1/256, C 33+255/256
    send("R7", 16'd54, G, 1'b0, Y, 1'b0);    // cost 34 no longer fits: P 1361
    cfg_len_off = 8'd0;

    // R6 packet mode, one token per packet
    cfg_pkt_mode = 1'b1; cfg_adj_man = 9'd384; cfg_adj_exp = 5'd1;
    for (int i = 0; i < 33; i++) send("R6", 16'd9000, G, 1'b0, G, 1'b0);
    send("R6", 16'd9000, G, 1'b0, Y, 1'b0);  // C 255/256
    cfg_adj_man = 9'd256; cfg_adj_exp = 5'd0;
    send("R7", 16'd9000, G, 1'b0, G, 1'b0);  // zero cost floored to 1/256
    cfg_pkt_mode = 1'b0;

    // R4 disabled buckets
    cfg_cbs_exp = 5'd24; cfg_cbs_man = 8'd0;
    send("R4", 16'd1, G, 1'b0, Y, 1'b0);
    cfg_pbs_exp = 5'd31; cfg_pbs_man = 8'd0;
    send("R4", 16'd1, G, 1'b0, R, 1'b1);

    // R1 buckets full after a fresh reset
    set_base();
    do_reset();
    send("R1", 16'd1024, G, 1'b0, G, 1'b0);
    send("R1", 16'd2048, G, 1'b0, Y, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule